// File: doc/BRIEF.md
# Segment Descriptor Table Search

This block turns the upper bits of a 64-bit effective address into a virtual segment identifier. It does this by searching a table of segment descriptors in memory. After a start pulse it reads the descriptors one at a time, beginning at the table base. For each valid descriptor it decodes a per-entry segment size, and that size picks the compare mask. The first descriptor whose tag equals the effective address under that mask ends the search. Only then does the block fetch that descriptor's attribute word.

The result is:
- the segment identifier, built from bits of both descriptor words;
- the page mask, which covers the offset inside the segment;
- a protection key, which depends on the privilege mode captured at start;
- a no-execute flag.

If no descriptor matches, the block raises a fault instead. The page-table walk that follows, and any writing of descriptors, belong to other blocks.

Memory is reached through a simple request/acknowledge port. The block issues one read at a time and waits for the acknowledge before it moves on.

Top module: `seg_walk`

## Requirements
- R1: After reset, busy, done, fault, key and nx are 0, and vsid and page_mask are all zero.
- R2: Descriptor doublewords are read as 64-bit reads (mem_dword=1), one per entry. Entry i is read at tbl_base + 12*i, in ascending order from entry 0. Reading stops at the first match.
- R3: A descriptor takes part in the search only when bit 27 of its doubleword is 1.
- R4: Doubleword bits 26:25 give the segment size, which sets the compare mask:
  - 00 compares bits 63:28;
  - 01 compares bits 63:48.
  A hit needs (ea XOR doubleword) to be zero under the mask. On a hit, page_mask is the inverse of that compare mask.
- R5: A descriptor whose size field is 10 or 11 is skipped, even if its valid bit is set and its tag matches.
- R6: When several descriptors match, the one with the lowest index gives the result.
- R7: vsid is bits 49:0 of ((doubleword << 24) | (word >> 8)), where word is the 32-bit attribute word of the matching entry.
- R8: key is 1 when priv_user was 1 at start and attribute bit 6 (0x40) is set. It is also 1 when priv_user was 0 at start and attribute bit 7 (0x80) is set. Otherwise key is 0.
- R9: nx equals attribute bit 5 (0x20). The attribute byte is bits 7:0 of the word.
- R10: If none of the 32 descriptors matches, done comes with fault=1, and vsid, page_mask, key and nx are all zero.
- R11: Exactly one attribute-word read is made per successful search, and none per failed search. It is a 32-bit read (mem_dword=0) at the matching entry's address + 8.
- R12: done is high for exactly one cycle. The result outputs hold until the next accepted start. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (taken only when idle) |
| ea | input | 64 | Effective address to translate |
| tbl_base | input | 64 | Byte address of descriptor 0 |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Read byte address |
| mem_dword | output | 1 | 1 = 64-bit read, 0 = 32-bit read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data (32-bit reads use bits 31:0) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | No descriptor matched |
| vsid | output | 50 | Virtual segment identifier |
| page_mask | output | 64 | Offset mask within the segment |
| key | output | 1 | Protection key |
| nx | output | 1 | Segment is no-execute |

## Verification
The search is driven with the following tables:
- a hit on a small segment behind invalid entries, which shows that the valid bit gates the search;
- a large-segment hit, where the address differs from the tag only below bit 48, which separates the two compare masks;
- reserved-size entries that would otherwise match, which must be skipped;
- two matching entries, which shows that the lowest index wins;
- a hit in the last slot, and a table with no match at all, which test the end of the walk and the fault result.

Each run counts the doubleword reads, the word reads and their addresses, so an early stop or an extra attribute fetch shows up. Key and no-execute are tried in both privilege modes with different attribute bytes. A second start pulse during a walk checks that the walk in progress is not disturbed.

// File: rtl/seg_walk_pkg.sv
package seg_walk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ_DW,
      ST_WAIT_DW,
      ST_REQ_W,
      ST_WAIT_W
   } walk_st_t;

   typedef enum logic [1:0] {
      SZ_SMALL = 2'b00,
      SZ_LARGE = 2'b01,
      SZ_RSV0  = 2'b10,
      SZ_RSV1  = 2'b11
   } seg_size_t;

   localparam int unsigned VALID_BIT = 27;
   localparam int unsigned SIZE_LSB  = 25;
   localparam int unsigned VSID_W    = 50;
   localparam int unsigned VSID_SHL  = 24;
   localparam int unsigned WORD_SHR  = 8;
endpackage

// File: rtl/seg_entry_dec.sv
module seg_entry_dec
   import seg_walk_pkg::*;
#(
   parameter int unsigned EA_W           = 64,
   parameter int unsigned SMALL_SEG_BITS = 28,
   parameter int unsigned LARGE_SEG_BITS = 48
) (
   input  logic [EA_W-1:0] dword,
   input  logic [EA_W-1:0] ea,
   output logic            hit,
   output logic [EA_W-1:0] cmp_mask
);
   localparam logic [EA_W-1:0] ONES       = '1;
   localparam logic [EA_W-1:0] MASK_SMALL = ONES << SMALL_SEG_BITS;
   localparam logic [EA_W-1:0] MASK_LARGE = ONES << LARGE_SEG_BITS;

   generate
      if (SMALL_SEG_BITS >= LARGE_SEG_BITS || LARGE_SEG_BITS >= EA_W) begin : g_bad_sizes
         $error("seg_entry_dec: segment size parameters out of order");
      end
   endgenerate

   seg_size_t size;
   logic      usable;

   always_comb begin
      size     = seg_size_t'(dword[SIZE_LSB +: 2]);
      usable   = dword[VALID_BIT];
      cmp_mask = '0;
      case (size)
         SZ_SMALL: cmp_mask = MASK_SMALL;
         SZ_LARGE: cmp_mask = MASK_LARGE;
         default: begin
            cmp_mask = '0;
            usable   = 1'b0;
         end
      endcase
      hit = usable && (((ea ^ dword) & cmp_mask) == '0);
   end
endmodule

// File: rtl/seg_result.sv
module seg_result
   import seg_walk_pkg::*;
#(
   parameter int unsigned EA_W = 64
) (
   input  logic [EA_W-1:0]   dword,
   input  logic [31:0]       word,
   input  logic              user_mode,
   output logic [VSID_W-1:0] vsid,
   output logic              key,
   output logic              nx
);
   logic [EA_W-1:0] joined;
   logic [7:0]      attr;

   always_comb begin
      joined = (dword << VSID_SHL) | (EA_W'(word) >> WORD_SHR);
      vsid   = joined[VSID_W-1:0];
      attr   = word[7:0];
      key    = (user_mode && attr[6]) || (!user_mode && attr[7]);
      nx     = attr[5];
   end
endmodule

// File: rtl/seg_walk.sv
module seg_walk
   import seg_walk_pkg::*;
#(
   parameter int unsigned EA_W           = 64,
   parameter int unsigned NUM_ENT        = 32,
   parameter int unsigned STRIDE         = 12,
   parameter int unsigned WORD_OFS       = 8,
   parameter int unsigned SMALL_SEG_BITS = 28,
   parameter int unsigned LARGE_SEG_BITS = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [63:0]       ea,
   input  logic [63:0]       tbl_base,
   input  logic              priv_user,
   output logic              mem_req,
   output logic [63:0]       mem_addr,
   output logic              mem_dword,
   input  logic              mem_ack,
   input  logic [63:0]       mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [49:0]       vsid,
   output logic [63:0]       page_mask,
   output logic              key,
   output logic              nx
);
   localparam int unsigned IDX_W = $clog2(NUM_ENT);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

   generate
      if (NUM_ENT < 2) begin : g_bad_depth
         $error("seg_walk: NUM_ENT must be at least 2");
      end
      if (WORD_OFS + 4 > STRIDE) begin : g_bad_stride
         $error("seg_walk: attribute word does not fit in the stride");
      end
      if (EA_W != 64) begin : g_bad_width
         $error("seg_walk: EA_W must be 64");
      end
   endgenerate

   walk_st_t         st;
   logic [IDX_W-1:0] idx;
   logic [63:0]      ent_addr;
   logic [63:0]      ea_q;
   logic             user_q;
   logic [63:0]      dw_q;
   logic [63:0]      mask_q;

   logic             dec_hit;
   logic [63:0]      dec_mask;
   logic [49:0]      res_vsid;
   logic             res_key;
   logic             res_nx;

   seg_entry_dec #(
      .EA_W(EA_W), .SMALL_SEG_BITS(SMALL_SEG_BITS), .LARGE_SEG_BITS(LARGE_SEG_BITS)
   ) u_dec (
      .dword(mem_rdata), .ea(ea_q), .hit(dec_hit), .cmp_mask(dec_mask)
   );

   seg_result #(.EA_W(EA_W)) u_res (
      .dword(dw_q), .word(mem_rdata[31:0]), .user_mode(user_q),
      .vsid(res_vsid), .key(res_key), .nx(res_nx)
   );

   assign busy      = (st != ST_IDLE);
   assign mem_req   = (st == ST_REQ_DW) || (st == ST_REQ_W);
   assign mem_dword = (st == ST_REQ_DW);
   assign mem_addr  = (st == ST_REQ_W) ? ent_addr + 64'(WORD_OFS) : ent_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         idx       <= '0;
         ent_addr  <= '0;
         ea_q      <= '0;
         user_q    <= 1'b0;
         dw_q      <= '0;
         mask_q    <= '0;
         done      <= 1'b0;
         fault     <= 1'b0;
         vsid      <= '0;
         page_mask <= '0;
         key       <= 1'b0;
         nx        <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  ea_q      <= ea;
                  user_q    <= priv_user;
                  ent_addr  <= tbl_base;
                  idx       <= '0;
                  fault     <= 1'b0;
                  vsid      <= '0;
                  page_mask <= '0;
                  key       <= 1'b0;
                  nx        <= 1'b0;
                  st        <= ST_REQ_DW;
               end
            end
            ST_REQ_DW: st <= ST_WAIT_DW;
            ST_WAIT_DW: begin
               if (mem_ack) begin
                  if (dec_hit) begin
                     dw_q   <= mem_rdata;
                     mask_q <= dec_mask;
                     st     <= ST_REQ_W;
                  end else if (idx == LAST_IDX) begin
                     fault <= 1'b1;
                     done  <= 1'b1;
                     st    <= ST_IDLE;
                  end else begin
                     idx      <= idx + 1'b1;
                     ent_addr <= ent_addr + 64'(STRIDE);
                     st       <= ST_REQ_DW;
                  end
               end
            end
            ST_REQ_W: st <= ST_WAIT_W;
            ST_WAIT_W: begin
               if (mem_ack) begin
                  vsid      <= res_vsid;
                  page_mask <= ~mask_q;
                  key       <= res_key;
                  nx        <= res_nx;
                  done      <= 1'b1;
                  st        <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(vsid) && $stable(fault) && $stable(page_mask)));

   // R10
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (vsid == '0 && page_mask == '0 && !key && !nx));

   // R2
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R11
   word_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_dword) |-> (mem_addr == $past(mem_addr, 2) + 64'(WORD_OFS)));

   // R12
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !fault && vsid == '0));
endmodule

// File: tb/tb_seg_walk.sv
module tb_seg_walk;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] ea = '0;
   logic [63:0] tbl_base = 64'h0000_0000_1000_0000;
   logic        priv_user = 1'b0;
   logic        mem_req, mem_dword, mem_ack;
   logic [63:0] mem_addr, mem_rdata;
   logic        busy, done, fault, key, nx;
   logic [49:0] vsid;
   logic [63:0] page_mask;

   int checks = 0;
   int errors = 0;

   logic [63:0] tdw [32];
   logic [31:0] twd [32];
   int dw_reads, w_reads, addr_bad;
   logic [63:0] last_w_addr;

   always #2 clk = ~clk;

   seg_walk dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .tbl_base(tbl_base),
      .priv_user(priv_user), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_dword(mem_dword), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .fault(fault), .vsid(vsid),
      .page_mask(page_mask), .key(key), .nx(nx)
   );

   // memory responder, two-cycle latency, acts on falling edges
   logic        pend = 1'b0;
   int          lat = 0;
   logic [63:0] paddr;
   logic        pdw;
   initial begin
      mem_ack = 1'b0;
      mem_rdata = '0;
   end
   always @(negedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req) begin
         pend  <= 1'b1;
         lat   <= 2;
         paddr <= mem_addr;
         pdw   <= mem_dword;
         if (mem_dword) begin
            if (mem_addr != tbl_base + 64'(12 * dw_reads)) addr_bad++;
            dw_reads++;
         end else begin
            w_reads++;
            last_w_addr = mem_addr;
         end
      end else if (pend) begin
         if (lat == 1) begin
            int i;
            int o;
            i = int'((paddr - tbl_base) / 12);
            o = int'((paddr - tbl_base) % 12);
            mem_ack   <= 1'b1;
            mem_rdata <= (pdw && o == 0) ? tdw[i] : {32'h0, twd[i]};
            pend      <= 1'b0;
         end
         lat <= lat - 1;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input logic v, input logic [1:0] sz,
                                       input logic [63:0] tag, input logic [24:0] lo);
      return tag | (64'(v) << 27) | (64'(sz) << 25) | 64'(lo);
   endfunction

   task automatic clear_tbl();
      for (int i = 0; i < 32; i++) begin
         tdw[i] = mk(1'b0, 2'b00, 64'hFFFF_FFFF_F000_0000, 25'h0);
         twd[i] = 32'h0;
      end
   endtask

   // reference result straight from the requirement text
   logic        e_fault, e_key, e_nx;
   logic [49:0] e_vsid;
   logic [63:0] e_mask, e_waddr;
   int          e_dw;
   task automatic ref_model(input logic [63:0] a, input logic user);
      logic [63:0] m, j;
      logic [7:0]  at;
      e_fault = 1'b1; e_vsid = '0; e_mask = '0; e_key = 0; e_nx = 0; e_dw = 32; e_waddr = '0;
      for (int i = 0; i < 32; i++) begin
         if (tdw[i][27] && tdw[i][26:25] != 2'b10 && tdw[i][26:25] != 2'b11) begin
            m = (tdw[i][26:25] == 2'b00) ? 64'hFFFF_FFFF_F000_0000 : 64'hFFFF_0000_0000_0000;
            if (((a ^ tdw[i]) & m) == 0) begin
               j = (tdw[i] << 24) | (64'(twd[i]) >> 8);
               at = twd[i][7:0];
               e_fault = 0; e_vsid = j[49:0]; e_mask = ~m;
               e_key = (user && at[6]) || (!user && at[7]);
               e_nx = at[5]; e_dw = i + 1;
               e_waddr = tbl_base + 64'(12 * i) + 64'd8;
               break;
            end
         end
      end
   endtask

   task automatic run_search(input string tag, input logic [63:0] a, input logic user);
      int t;
      ref_model(a, user);
      dw_reads = 0; w_reads = 0; addr_bad = 0;
      @(negedge clk);
      ea = a; priv_user = user; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk({tag, " R12 done seen"}, 64'(done), 64'd1);
      chk({tag, " R10 fault"}, 64'(fault), 64'(e_fault));
      chk({tag, " R7 vsid"}, 64'(vsid), 64'(e_vsid));
      chk({tag, " R4 page_mask"}, page_mask, e_mask);
      chk({tag, " R8 key"}, 64'(key), 64'(e_key));
      chk({tag, " R9 nx"}, 64'(nx), 64'(e_nx));
      chk({tag, " R2 dword reads"}, 64'(dw_reads), 64'(e_dw));
      chk({tag, " R2 dword addresses"}, 64'(addr_bad), 64'd0);
      chk({tag, " R11 word reads"}, 64'(w_reads), e_fault ? 64'd0 : 64'd1);
      if (!e_fault) chk({tag, " R11 word address"}, last_w_addr, e_waddr);
      @(negedge clk);
      chk({tag, " R12 done one cycle"}, 64'(done), 64'd0);
      chk({tag, " R12 vsid held"}, 64'(vsid), 64'(e_vsid));
   endtask

   task automatic t_reset();
      chk("R1 busy", 64'(busy), 0);
      chk("R1 done", 64'(done), 0);
      chk("R1 fault", 64'(fault), 0);
      chk("R1 vsid", 64'(vsid), 0);
      chk("R1 page_mask", page_mask, 0);
      chk("R1 key nx", {62'h0, key, nx}, 0);
   endtask

   task automatic t_small_hit();
      clear_tbl();
      tdw[2] = mk(1'b0, 2'b00, 64'h1234_5678_A000_0000, 25'h1ABCDE);
      tdw[5] = mk(1'b1, 2'b00, 64'h1234_5678_A000_0000, 25'h0F0F0F);
      twd[5] = 32'hC3D2_E1_65;
      run_search("R3 small", 64'h1234_5678_A765_4321, 1'b1);
   endtask

   task automatic t_large_hit();
      clear_tbl();
      tdw[1] = mk(1'b1, 2'b00, 64'h7777_0000_0000_0000, 25'h0);
      tdw[3] = mk(1'b1, 2'b01, 64'h7777_0000_0000_0000, 25'h155555);
      twd[3] = 32'h89AB_CD_A0;
      run_search("R4 large", 64'h7777_1234_5678_9ABC, 1'b0);
   endtask

   task automatic t_reserved();
      clear_tbl();
      tdw[0] = mk(1'b1, 2'b10, 64'h4000_0000_0000_0000, 25'h1);
      tdw[1] = mk(1'b1, 2'b11, 64'h4000_0000_0000_0000, 25'h2);
      tdw[2] = mk(1'b1, 2'b00, 64'h4000_0000_0000_0000, 25'h3);
      twd[0] = 32'hFFFF_FF_FF;
      twd[2] = 32'h0000_11_40;
      run_search("R5 reserved", 64'h4000_0000_0000_0000, 1'b1);
   endtask

   task automatic t_first_wins();
      clear_tbl();
      tdw[3] = mk(1'b1, 2'b00, 64'h0000_0000_5000_0000, 25'h0AAAAA);
      tdw[4] = mk(1'b1, 2'b01, 64'h0000_0000_0000_0000, 25'h155555);
      twd[3] = 32'h1111_11_80;
      twd[4] = 32'h2222_22_20;
      run_search("R6 first", 64'h0000_0000_5123_4567, 1'b0);
   endtask

   task automatic t_last_and_miss();
      clear_tbl();
      tdw[31] = mk(1'b1, 2'b00, 64'hDEAD_BEEF_0000_0000, 25'h1FFFFFF);
      twd[31] = 32'hFEDC_BA_E0;
      run_search("R2 last slot", 64'hDEAD_BEEF_0FFF_FFFF, 1'b1);
      tdw[31] = mk(1'b1, 2'b00, 64'hDEAD_BEEF_1000_0000, 25'h0);
      run_search("R10 miss", 64'hDEAD_BEEF_0FFF_FFFF, 1'b1);
   endtask

   task automatic t_key_modes();
      clear_tbl();
      tdw[0] = mk(1'b1, 2'b00, 64'h0000_0001_0000_0000, 25'h0);
      twd[0] = 32'h0000_00_40;
      run_search("R8 user 0x40", 64'h0000_0001_0000_0010, 1'b1);
      run_search("R8 super 0x40", 64'h0000_0001_0000_0010, 1'b0);
      twd[0] = 32'h0000_00_80;
      run_search("R8 super 0x80", 64'h0000_0001_0000_0010, 1'b0);
      run_search("R8 user 0x80", 64'h0000_0001_0000_0010, 1'b1);
   endtask

   task automatic t_busy_start();
      int t;
      clear_tbl();
      tdw[6] = mk(1'b1, 2'b00, 64'h0000_0002_0000_0000, 25'h123);
      twd[6] = 32'h5555_55_C0;
      tdw[1] = mk(1'b1, 2'b00, 64'h0000_0009_0000_0000, 25'h456);
      twd[1] = 32'h6666_66_00;
      ref_model(64'h0000_0002_0000_0000, 1'b1);
      dw_reads = 0; w_reads = 0; addr_bad = 0;
      @(negedge clk);
      ea = 64'h0000_0002_0000_0000; priv_user = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      ea = 64'h0000_0009_0000_0000; priv_user = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk("R12 busy start vsid", 64'(vsid), 64'(e_vsid));
      chk("R12 busy start key", 64'(key), 64'(e_key));
      chk("R12 busy start reads", 64'(dw_reads), 64'(e_dw));
   endtask

   initial begin
      clear_tbl();
      dw_reads = 0; w_reads = 0; addr_bad = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_small_hit();
      t_large_hit();
      t_reserved();
      t_first_wins();
      t_last_and_miss();
      t_key_modes();
      t_busy_start();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule